// File: doc/BRIEF.md
# Key-Guarded Oscillator Configuration Register

This block is a single 8-bit configuration register on a plain write bus. The register drives the clock-system controls: enables for three oscillators, enables for two clock-failure detectors, a flash power-down control and a 2-bit system clock source select. A stray write could stop the system clock, so the register only takes a write after a two-byte key has been written to its own address. It locks again by itself after each accepted write.

The write bus has an address, a data byte and a one-cycle write strobe. The register decodes one address. Writes to any other address pass by without effect. The current contents always appear on a readback output, and each field also has its own output pin. A low-power option input sets the reset value of the flash power-down bit.

Top module: `osc_cfg_lockreg`

## Requirements
- R1: While reset is held, the register loads 0xA4 when `lp_opt_i` is 0 and 0xA0 when `lp_opt_i` is 1. Bits 7 and 5 reset to 1, bit 2 resets to the inverse of `lp_opt_i`, and every other bit resets to 0.
- R2: While the register is locked, a write to address 0xF86 with a byte that is not a key leaves the contents unchanged.
- R3: Writing 0xE7 and then 0x18 to address 0xF86 unlocks the register. The next write to 0xF86 is stored, and `rdata_o` shows it from the clock edge that samples the write.
- R4: After one accepted data write the register is locked again, and a further data write is ignored.
- R5: If a byte other than 0x18 or 0xE7 is written right after 0xE7, the sequence returns to idle. A following 0x18 then does not unlock the register.
- R6: If 0xE7 is written again right after 0xE7, the sequence restarts, so the writes E7, E7, 18 unlock the register.
- R7: Key bytes are never stored. The contents stay unchanged across both key writes.
- R8: A write to any address other than 0xF86 does not change the contents and does not move the unlock sequence. A key byte sent to another address does not count toward the key.
- R9: The field outputs follow the stored bits: bit 7 `int_osc_en_o`, bit 6 `xtal_en_o`, bit 5 `wdog_osc_en_o`, bit 4 `pri_fail_det_en_o`, bit 3 `wdog_fail_det_en_o`, bit 2 `flash_pd_o`, bits 1:0 `clk_src_sel_o`.
- R10: When the register is unlocked, a data byte equal to 0xE7 is stored as data and the register relocks. A 0x18 written next is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_opt_i | input | 1 | Low-power option; selects the flash power-down reset value |
| bus_addr_i | input | 12 | Write address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| wdog_osc_en_o | output | 1 | Watchdog oscillator enable |
| pri_fail_det_en_o | output | 1 | Primary clock failure detection enable |
| wdog_fail_det_en_o | output | 1 | Watchdog clock failure detection enable |
| flash_pd_o | output | 1 | Flash power-down control |
| clk_src_sel_o | output | 2 | System clock source select |
| rdata_o | output | 8 | Current register contents |

## Verification
The lock state has no port, so the bench can only see it by trying a data write with a marker byte and watching whether `rdata_o` changes. The hardest case is a half-finished key: an E7 followed by a wrong byte, by a second E7, or by a write to a foreign address. For each case the bench completes the sequence and then sends a marker write. Whether the marker is stored shows which state the sequence was in.

// File: rtl/osc_lock_pkg.sv
package osc_lock_pkg;

    localparam int unsigned CFG_W = 8;

    localparam int unsigned POS_INT_OSC   = 7;
    localparam int unsigned POS_XTAL      = 6;
    localparam int unsigned POS_WDOG_OSC  = 5;
    localparam int unsigned POS_PRI_FAIL  = 4;
    localparam int unsigned POS_WDOG_FAIL = 3;
    localparam int unsigned POS_FLASH_PD  = 2;
    localparam int unsigned POS_SEL_HI    = 1;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_KEY1 = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_e;

    typedef struct packed {
        lock_state_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic [CFG_W-1:0] val;
    } store_regs_t;

    function automatic logic [CFG_W-1:0] cfg_reset_val(input logic lp_opt);
        logic [CFG_W-1:0] v;
        v = '0;
        v[POS_INT_OSC]  = 1'b1;
        v[POS_WDOG_OSC] = 1'b1;
        v[POS_FLASH_PD] = ~lp_opt;
        return v;
    endfunction

endpackage

// File: rtl/osc_unlock_fsm.sv
module osc_unlock_fsm
    import osc_lock_pkg::*;
#(
    parameter logic [CFG_W-1:0] KEY_FIRST  = 8'hE7,
    parameter logic [CFG_W-1:0] KEY_SECOND = 8'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_we,
    input  logic [CFG_W-1:0] wdata,
    output logic             wr_acc,
    output lock_state_e      state_o
);

    fsm_regs_t q, d;

    always_comb begin
        d      = q;
        wr_acc = 1'b0;
        if (hit_we) begin
            unique case (q.state)
                LK_IDLE: begin
                    if (wdata == KEY_FIRST) d.state = LK_KEY1;
                end
                LK_KEY1: begin
                    if (wdata == KEY_SECOND)     d.state = LK_OPEN;
                    else if (wdata == KEY_FIRST) d.state = LK_KEY1;
                    else                         d.state = LK_IDLE;
                end
                LK_OPEN: begin
                    wr_acc  = 1'b1;
                    d.state = LK_IDLE;
                end
                default: d.state = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.state <= LK_IDLE;
        else        q <= d;
    end

    assign state_o = q.state;

endmodule

// File: rtl/osc_cfg_store.sv
module osc_cfg_store
    import osc_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_opt,
    input  logic             wr_acc,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] val_o
);

    store_regs_t q, d;

    always_comb begin
        d = q;
        if (wr_acc) d.val = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.val <= cfg_reset_val(lp_opt);
        else        q <= d;
    end

    assign val_o = q.val;

endmodule

// File: rtl/osc_cfg_lockreg.sv
module osc_cfg_lockreg
    import osc_lock_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 12'hF86,
    parameter logic [CFG_W-1:0]  KEY_FIRST  = 8'hE7,
    parameter logic [CFG_W-1:0]  KEY_SECOND = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_opt_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CFG_W-1:0]  bus_wdata_i,
    input  logic              bus_we_i,
    output logic              int_osc_en_o,
    output logic              xtal_en_o,
    output logic              wdog_osc_en_o,
    output logic              pri_fail_det_en_o,
    output logic              wdog_fail_det_en_o,
    output logic              flash_pd_o,
    output logic [1:0]        clk_src_sel_o,
    output logic [CFG_W-1:0]  rdata_o
);

    logic             hit_we;
    logic             wr_acc;
    lock_state_e      lk_state;
    logic [CFG_W-1:0] cfg_val;

    assign hit_we = bus_we_i && (bus_addr_i == REG_ADDR);

    osc_unlock_fsm #(
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_we (hit_we),
        .wdata  (bus_wdata_i),
        .wr_acc (wr_acc),
        .state_o(lk_state)
    );

    osc_cfg_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .lp_opt(lp_opt_i),
        .wr_acc(wr_acc),
        .wdata (bus_wdata_i),
        .val_o (cfg_val)
    );

    assign int_osc_en_o       = cfg_val[POS_INT_OSC];
    assign xtal_en_o          = cfg_val[POS_XTAL];
    assign wdog_osc_en_o      = cfg_val[POS_WDOG_OSC];
    assign pri_fail_det_en_o  = cfg_val[POS_PRI_FAIL];
    assign wdog_fail_det_en_o = cfg_val[POS_WDOG_FAIL];
    assign flash_pd_o         = cfg_val[POS_FLASH_PD];
    assign clk_src_sel_o      = cfg_val[POS_SEL_HI:0];
    assign rdata_o            = cfg_val;

endmodule

// File: rtl/osc_cfg_lock_chk.sv
module osc_cfg_lock_chk
    import osc_lock_pkg::*;
#(
    parameter logic [CFG_W-1:0] KEY_FIRST  = 8'hE7,
    parameter logic [CFG_W-1:0] KEY_SECOND = 8'h18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_we,
    input logic             wr_acc,
    input lock_state_e      lk_state,
    input logic [CFG_W-1:0] wdata,
    input logic [CFG_W-1:0] rdata,
    input logic             f_int,
    input logic             f_xtal,
    input logic             f_wdog,
    input logic             f_pfail,
    input logic             f_wfail,
    input logic             f_fpd,
    input logic [1:0]       f_sel
);

    // A write that is not accepted leaves the contents unchanged.
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(rdata));

    // Both key bytes in order open the register.
    assert_key_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_we && lk_state == LK_KEY1 && wdata == KEY_SECOND) |=> lk_state == LK_OPEN);

    // An accepted write shows up on the readback.
    assert_store_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> rdata == $past(wdata));

    // The register relocks after one accepted write.
    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> lk_state == LK_IDLE);

    // A wrong byte after the first key returns the sequence to idle.
    assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_we && lk_state == LK_KEY1 && wdata != KEY_SECOND && wdata != KEY_FIRST)
        |=> lk_state == LK_IDLE);

    // A repeated first key keeps the sequence waiting for the second key.
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_we && lk_state == LK_KEY1 && wdata == KEY_FIRST) |=> lk_state == LK_KEY1);

    // Writes to other addresses do not move the sequence.
    assert_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_we |=> $stable(lk_state));

    // The field outputs match the readback bits.
    assert_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        {f_int, f_xtal, f_wdog, f_pfail, f_wfail, f_fpd, f_sel} == rdata);

endmodule

bind osc_cfg_lockreg osc_cfg_lock_chk #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_we  (hit_we),
    .wr_acc  (wr_acc),
    .lk_state(lk_state),
    .wdata   (bus_wdata_i),
    .rdata   (rdata_o),
    .f_int   (int_osc_en_o),
    .f_xtal  (xtal_en_o),
    .f_wdog  (wdog_osc_en_o),
    .f_pfail (pri_fail_det_en_o),
    .f_wfail (wdog_fail_det_en_o),
    .f_fpd   (flash_pd_o),
    .f_sel   (clk_src_sel_o)
);

// File: tb/tb_osc_cfg_lockreg.sv
`timescale 1ns/1ps
module tb_osc_cfg_lockreg;

    localparam logic [11:0] REG_A = 12'hF86;
    localparam logic [11:0] OTH_A = 12'h123;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_opt = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;
    logic        f_int, f_xtal, f_wdog, f_pfail, f_wfail, f_fpd;
    logic [1:0]  f_sel;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    osc_cfg_lockreg dut (
        .clk(clk), .rst_n(rst_n), .lp_opt_i(lp_opt),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
        .int_osc_en_o(f_int), .xtal_en_o(f_xtal), .wdog_osc_en_o(f_wdog),
        .pri_fail_det_en_o(f_pfail), .wdog_fail_det_en_o(f_wfail),
        .flash_pd_o(f_fpd), .clk_src_sel_o(f_sel), .rdata_o(rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_reset(input logic lp);
        @(negedge clk);
        lp_opt = lp; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_wr(REG_A, 8'hE7);
        bus_wr(REG_A, 8'h18);
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        chk("R1 reset lp=1", rdata, 8'hA0);
        do_reset(1'b0);
        chk("R1 reset lp=0", rdata, 8'hA4);
        chk("R9 fields at reset",
            {f_int, f_xtal, f_wdog, f_pfail, f_wfail, f_fpd, f_sel}, 8'hA4);
    endtask

    task automatic t_locked_write();
        bus_wr(REG_A, 8'h55);
        chk("R2 locked write ignored", rdata, 8'hA4);
    endtask

    task automatic t_unlock_write();
        bus_wr(REG_A, 8'hE7);
        chk("R7 after first key", rdata, 8'hA4);
        bus_wr(REG_A, 8'h18);
        chk("R7 after second key", rdata, 8'hA4);
        bus_wr(REG_A, 8'h3C);
        chk("R3 data stored", rdata, 8'h3C);
        chk("R9 fields of 3C",
            {f_int, f_xtal, f_wdog, f_pfail, f_wfail, f_fpd, f_sel}, 8'h3C);
        bus_wr(REG_A, 8'hFF);
        chk("R4 relocked", rdata, 8'h3C);
    endtask

    task automatic t_bad_key();
        bus_wr(REG_A, 8'hE7);
        bus_wr(REG_A, 8'h42);
        bus_wr(REG_A, 8'h18);
        bus_wr(REG_A, 8'h11);
        chk("R5 wrong second key", rdata, 8'h3C);
    endtask

    task automatic t_restart();
        bus_wr(REG_A, 8'hE7);
        bus_wr(REG_A, 8'hE7);
        bus_wr(REG_A, 8'h18);
        bus_wr(REG_A, 8'h81);
        chk("R6 repeated first key", rdata, 8'h81);
    endtask

    task automatic t_foreign();
        bus_wr(OTH_A, 8'h00);
        chk("R8 foreign write locked", rdata, 8'h81);
        bus_wr(REG_A, 8'hE7);
        bus_wr(OTH_A, 8'h00);
        bus_wr(REG_A, 8'h18);
        bus_wr(OTH_A, 8'h77);
        chk("R8 foreign write while open", rdata, 8'h81);
        bus_wr(REG_A, 8'h5A);
        chk("R8 sequence kept across foreign", rdata, 8'h5A);
        bus_wr(OTH_A, 8'hE7);
        bus_wr(REG_A, 8'h18);
        bus_wr(REG_A, 8'hF0);
        chk("R8 key to foreign address", rdata, 8'h5A);
    endtask

    task automatic t_key_as_data();
        unlock();
        bus_wr(REG_A, 8'hE7);
        chk("R10 E7 stored as data", rdata, 8'hE7);
        bus_wr(REG_A, 8'h18);
        bus_wr(REG_A, 8'h66);
        chk("R10 no unlock after data E7", rdata, 8'hE7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_locked_write();
        t_unlock_write();
        t_bad_key();
        t_restart();
        t_foreign();
        t_key_as_data();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule